// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 64 interrupt sources for one processor. A rising edge on any source input sets a pending flag for that source. A per-source enable flag decides whether the flag takes part in arbitration. Every source carries a 3-bit urgency value, where a smaller value is more urgent. Values 0 and 1 send the source to the fast-request output. Values 2 to 7 send it to the normal-request output.

Software works the block through a plain read/write strobe bus with 32-bit words. It clears pending flags by writing ones to them and sets the enables and urgency values. It then reads an entry word that names the most urgent enabled pending source on the normal path. The entry word is a programmable base plus four times the source index plus one. A base of zero lets software shift right by two and subtract one to get the index.

A freeze control holds the registered arbitration outputs steady. Software can use it to read a snapshot that does not change.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, every pending flag, enable, urgency value, the entry base and the freeze bit are 0. Both request outputs are low. A read of the entry word at 0x14 returns 0.
- R2: A source input going from 0 to 1 sets its pending flag at that clock edge. The request output rises one clock later. A source held high does not set the flag again after it has been cleared.
- R3: The status words hold one bit per source, with bit k meaning source 32*w+k. The fast words are at 0x00/0x04 and show pending flags of urgency 0–1. The normal words are at 0x08/0x0C and show pending flags of urgency 2–7. Writing 1 to a bit clears that pending flag only if the source is routed to the word written. Writing 0 changes nothing.
- R4: When a rising edge and a write-1 clear of the same flag arrive in the same cycle, the flag ends up set.
- R5: A pending source whose enable bit is 0 raises no request. The enables are at 0x18 (sources 0–31) and 0x1C (sources 32–63).
- R6: The urgency words are at 0x30 + 4*r and hold sources 8r to 8r+7 in 4-bit slots, with source 8r in bits [3:0]. Only the low 3 bits of each slot are stored. The top bit of each slot reads back as 0.
- R7: The entry word at 0x14 reads as base + ((index + 1) << 2) for the winning source. When no enabled pending source is on the normal path, it reads as the base alone. The base is written at 0x24.
- R8: Among enabled pending sources on the normal path, the lowest urgency value wins. Between equal values, the lower source index wins.
- R9: An urgency value of 0 or 1 drives the fast-request output and leaves the normal-request output and the entry word alone. A value of 2 to 7 drives the normal-request output.
- R10: With freeze at 0, clearing an enable bit takes the source out of arbitration at the same edge. The request output and the entry word follow one clock later.
- R11: When bit 0 of the control word at 0x20 is 1, both request outputs and the entry word hold their values. They resume tracking one clock after the bit returns to 0.
- R12: Read data appears on the clock after the read strobe. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | N | Edge-triggered interrupt source lines |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| irq_req | output | 1 | Normal-path request to the processor |
| fiq_req | output | 1 | Fast-path request to the processor |

## Verification
The bench builds the block at its default sizes: 64 sources, an 8-bit offset and 3-bit urgency values. At these sizes both words of every register pair are in use. Sources in the upper word (33, 40, 50) are tested against sources in the lower word for priority and clearing. The last urgency word (0x4C) and the unmapped holes at 0x10, 0x28 and 0x50 can also be reached. Each ordering case is a short sequence of edges and clears, with the entry word predicted from the index formula at each step.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W      = 32;
  localparam int SLOT_W     = 4;
  localparam int FAST_LVLS  = 2;
  localparam int OFF_FAST   = 'h00;
  localparam int OFF_NORM   = 'h08;
  localparam int OFF_ENTRY  = 'h14;
  localparam int OFF_EN     = 'h18;
  localparam int OFF_CTL    = 'h20;
  localparam int OFF_BASE   = 'h24;
  localparam int OFF_PRIO   = 'h30;
endpackage

// File: rtl/intc_edge_pend.sv
module intc_edge_pend #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] rise
);
  logic [N-1:0] src_q;

  assign rise = src & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      pend  <= '0;
    end else begin
      src_q <= src;
      pend  <= (pend & ~clr) | rise;   // a new edge beats a clear
    end
  end
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
  parameter int N  = 64,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx
);
  logic [PW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lower index on a tie
      if (cand[i] && (!found || prio[i*PW +: PW] < best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
  import intc_pkg::*;
#(
  parameter int N  = 64,
  parameter int AW = 8,
  parameter int PW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     fast_route,
  input  logic [REG_W-1:0] entry,
  output logic [REG_W-1:0] bus_rdata,
  output logic [N-1:0]     en,
  output logic [N-1:0]     clr,
  output logic [N*PW-1:0]  prio,
  output logic [REG_W-1:0] base,
  output logic             freeze
);
  localparam int NW  = N / REG_W;
  localparam int SPR = REG_W / SLOT_W;
  localparam int NP  = N / SPR;

  logic [REG_W-1:0] rd_mux;

  function automatic logic hit(input logic [AW-1:0] a, input int off);
    return a == AW'(off);
  endfunction

  always_comb begin
    clr = '0;
    for (int w = 0; w < NW; w++) begin
      if (bus_wr && hit(bus_addr, OFF_FAST + 4*w))
        clr[w*REG_W +: REG_W] = bus_wdata & fast_route[w*REG_W +: REG_W];
      if (bus_wr && hit(bus_addr, OFF_NORM + 4*w))
        clr[w*REG_W +: REG_W] = bus_wdata & ~fast_route[w*REG_W +: REG_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NW; w++) begin
      if (hit(bus_addr, OFF_FAST + 4*w))
        rd_mux = pend[w*REG_W +: REG_W] & fast_route[w*REG_W +: REG_W];
      if (hit(bus_addr, OFF_NORM + 4*w))
        rd_mux = pend[w*REG_W +: REG_W] & ~fast_route[w*REG_W +: REG_W];
      if (hit(bus_addr, OFF_EN + 4*w))
        rd_mux = en[w*REG_W +: REG_W];
    end
    if (hit(bus_addr, OFF_ENTRY)) rd_mux = entry;
    if (hit(bus_addr, OFF_CTL))   rd_mux = {{(REG_W-1){1'b0}}, freeze};
    if (hit(bus_addr, OFF_BASE))  rd_mux = base;
    for (int r = 0; r < NP; r++) begin
      if (hit(bus_addr, OFF_PRIO + 4*r)) begin
        for (int s = 0; s < SPR; s++)
          rd_mux[s*SLOT_W +: PW] = prio[(r*SPR+s)*PW +: PW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= '0;
      prio      <= '0;
      base      <= '0;
      freeze    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      if (bus_wr) begin
        for (int w = 0; w < NW; w++)
          if (hit(bus_addr, OFF_EN + 4*w)) en[w*REG_W +: REG_W] <= bus_wdata;
        for (int r = 0; r < NP; r++) begin
          if (hit(bus_addr, OFF_PRIO + 4*r)) begin
            for (int s = 0; s < SPR; s++)
              prio[(r*SPR+s)*PW +: PW] <= bus_wdata[s*SLOT_W +: PW];
          end
        end
        if (hit(bus_addr, OFF_CTL))  freeze <= bus_wdata[0];
        if (hit(bus_addr, OFF_BASE)) base   <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int N  = 64,
  parameter int AW = 8,
  parameter int PW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     src,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq_req,
  output logic             fiq_req
);
  localparam int IW = $clog2(N);

  logic [N-1:0]     pend, rise, clr, en, fast_route, norm_cand, fast_cand;
  logic [N*PW-1:0]  prio;
  logic [REG_W-1:0] base, entry_q;
  logic             freeze, win_found;
  logic [IW-1:0]    win_idx;

  intc_edge_pend #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .src(src), .clr(clr), .pend(pend), .rise(rise)
  );

  intc_regbank #(.N(N), .AW(AW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend(pend),
    .fast_route(fast_route), .entry(entry_q), .bus_rdata(bus_rdata),
    .en(en), .clr(clr), .prio(prio), .base(base), .freeze(freeze)
  );

  for (genvar i = 0; i < N; i++) begin : g_route
    assign fast_route[i] = prio[i*PW +: PW] < PW'(FAST_LVLS);
  end

  assign fast_cand = pend & en & fast_route;
  assign norm_cand = pend & en & ~fast_route;

  intc_prio_arb #(.N(N), .PW(PW)) u_arb (
    .cand(norm_cand), .prio(prio), .found(win_found), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      fiq_req <= 1'b0;
      entry_q <= '0;
    end else if (!freeze) begin
      irq_req <= |norm_cand;
      fiq_req <= |fast_cand;
      entry_q <= win_found ? base + ((REG_W'(win_idx) + REG_W'(1)) << 2) : base;
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int N  = 64,
  parameter int AW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     rise,
  input logic [N-1:0]     clr,
  input logic [N-1:0]     en,
  input logic             freeze,
  input logic [REG_W-1:0] entry_q,
  input logic             irq_req,
  input logic             fiq_req,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [REG_W-1:0] bus_rdata
);
  localparam int NW = N / REG_W;
  localparam int NP = N / (REG_W / SLOT_W);

  logic mapped;
  always_comb begin
    mapped = (bus_addr[1:0] == 2'b00) &&
             ((bus_addr < AW'(OFF_NORM + 4*NW)) ||
              (bus_addr == AW'(OFF_ENTRY)) ||
              (bus_addr >= AW'(OFF_EN) && bus_addr < AW'(OFF_EN + 4*NW)) ||
              (bus_addr == AW'(OFF_CTL)) || (bus_addr == AW'(OFF_BASE)) ||
              (bus_addr >= AW'(OFF_PRIO) && bus_addr < AW'(OFF_PRIO + 4*NP)));
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend & $past(rise)) == $past(rise))); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend & $past(clr & ~rise)) == '0)); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(freeze) && ($past(en) == '0)) |-> (!irq_req && !fiq_req)); // R5
  AST_FROZEN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(freeze)) |-> ($stable(entry_q) && $stable(irq_req))); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rd) && !$past(mapped)) |-> (bus_rdata == '0)); // R12
endmodule

bind prio_vec_intc intc_checker #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .pend(pend), .rise(rise), .clr(clr), .en(en),
  .freeze(freeze), .entry_q(entry_q), .irq_req(irq_req), .fiq_req(fiq_req),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  localparam int N = 64;
  localparam int AW = 8;
  localparam logic [7:0] A_FST0 = 8'h00, A_NRM0 = 8'h08, A_NRM1 = 8'h0C,
    A_ENT = 8'h14, A_EN0 = 8'h18, A_EN1 = 8'h1C, A_CTL = 8'h20,
    A_BASE = 8'h24, A_PR0 = 8'h30;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_req, fiq_req;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_vec_intc dut (
    .clk(clk), .rst(rst), .src(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", 32'(irq_req), 0);
    check("R1 fiq", 32'(fiq_req), 0);
    rd(A_ENT, v);  check("R1 entry", v, 0);
    rd(A_EN1, v);  check("R1 enable", v, 0);
    rd(A_PR0, v);  check("R1 prio", v, 0);
    rd(A_CTL, v);  check("R1 ctl", v, 0);
  endtask

  task automatic t_prio_pack;
    logic [31:0] v;
    wr(A_PR0, 32'hF9A3B2C1);
    rd(A_PR0, v); check("R6 slot pack", v, 32'h71233241);
    for (int r = 0; r < 8; r++) wr(A_PR0 + 8'(4*r), 32'h44444444);
    rd(A_PR0 + 8'h1C, v); check("R6 last word", v, 32'h44444444);
    wr(A_EN0, '1); wr(A_EN1, '1);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    src[5] = 1'b1;
    tick(1); check("R2 not yet", 32'(irq_req), 0);
    tick(1); check("R2 irq up", 32'(irq_req), 1);
    rd(A_NRM0, v); check("R3 status", v, 32'h20);
    rd(A_ENT, v);  check("R7 entry idx5", v, 32'd24);
    wr(A_NRM0, 32'h20);
    tick(2);
    check("R2 held level no reset", 32'(irq_req), 0);
    rd(A_NRM0, v); check("R2 status cleared", v, 0);
    src[5] = 1'b0; tick(1);
  endtask

  task automatic t_clear_zero;
    logic [31:0] v;
    src[3] = 1'b1; src[40] = 1'b1; tick(1);
    wr(A_NRM0, 32'h0);
    wr(A_FST0, '1);
    rd(A_NRM0, v); check("R3 zero/other word keeps", v, 32'h8);
    rd(A_NRM1, v); check("R3 upper word", v, 32'h100);
    wr(A_NRM0, '1); wr(A_NRM1, '1);
    rd(A_NRM0, v); check("R3 all ones lo", v, 0);
    rd(A_NRM1, v); check("R3 all ones hi", v, 0);
    src[3] = 1'b0; src[40] = 1'b0; tick(1);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    src[7] = 1'b1;
    wr(A_NRM0, 32'h80);
    rd(A_NRM0, v); check("R4 set beats clear", v, 32'h80);
    src[7] = 1'b0;
    wr(A_NRM0, 32'h80); tick(1);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(A_PR0 + 8'h04, 32'h44444544);  // src10 -> 5
    wr(A_PR0 + 8'h08, 32'h44434444);  // src20 -> 3
    wr(A_PR0 + 8'h18, 32'h44444344);  // src50 -> 3
    src[10] = 1'b1; src[20] = 1'b1; src[50] = 1'b1;
    tick(2);
    rd(A_ENT, v); check("R8 lowest value, low index", v, 32'd84);
    wr(A_NRM0, 32'h100000); tick(1);
    rd(A_ENT, v); check("R8 next src50", v, 32'd204);
    wr(A_NRM1, 32'h40000); tick(1);
    rd(A_ENT, v); check("R8 last src10", v, 32'd44);
    wr(A_NRM0, 32'h400); tick(1);
    rd(A_ENT, v); check("R7 none is base", v, 0);
    check("R7 irq low", 32'(irq_req), 0);
    src[10] = 1'b0; src[20] = 1'b0; src[50] = 1'b0;
    wr(A_PR0 + 8'h04, 32'h44444444);
    wr(A_PR0 + 8'h08, 32'h44444444);
    wr(A_PR0 + 8'h18, 32'h44444444);
  endtask

  task automatic t_fast;
    logic [31:0] v;
    wr(A_PR0 + 8'h04, 32'h44414444);  // src12 -> 1
    src[12] = 1'b1; tick(2);
    check("R9 fiq up", 32'(fiq_req), 1);
    check("R9 irq idle", 32'(irq_req), 0);
    rd(A_ENT, v);  check("R9 entry ignores fast", v, 0);
    rd(A_FST0, v); check("R9 fast status", v, 32'h1000);
    src[33] = 1'b1; tick(2);
    check("R9 irq up", 32'(irq_req), 1);
    rd(A_ENT, v);  check("R9 entry src33", v, 32'd136);
    src[12] = 1'b0; src[33] = 1'b0;
    wr(A_FST0, 32'h1000); wr(A_NRM1, 32'h2); tick(1);
    check("R9 fiq cleared", 32'(fiq_req), 0);
    wr(A_PR0 + 8'h04, 32'h44444444);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    src[2] = 1'b1; tick(2);
    check("R10 irq up", 32'(irq_req), 1);
    wr(A_EN0, ~32'h4);
    check("R10 one clock later", 32'(irq_req), 1);
    tick(1);
    check("R10 removed", 32'(irq_req), 0);
    rd(A_ENT, v); check("R10 entry base", v, 0);
    rd(A_NRM0, v); check("R5 still pending", v, 32'h4);
    src[2] = 1'b0;
    wr(A_NRM0, 32'h4); wr(A_EN0, '1);
  endtask

  task automatic t_base;
    logic [31:0] v;
    wr(A_BASE, 32'h1000);
    src[9] = 1'b1; tick(2);
    rd(A_ENT, v); check("R7 base plus idx9", v, 32'h1028);
    src[9] = 1'b0; wr(A_NRM0, 32'h200); tick(1);
    rd(A_ENT, v); check("R7 base alone", v, 32'h1000);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    wr(A_CTL, 32'h1);
    src[15] = 1'b1; tick(2);
    check("R11 irq held", 32'(irq_req), 0);
    rd(A_ENT, v); check("R11 entry held", v, 32'h1000);
    wr(A_CTL, 32'h0);
    tick(1);
    check("R11 irq resumes", 32'(irq_req), 1);
    rd(A_ENT, v); check("R11 entry resumes", v, 32'h1040);
    src[15] = 1'b0; wr(A_NRM0, 32'h8000);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(8'h10, v); check("R12 hole 0x10", v, 0);
    rd(8'h28, v); check("R12 hole 0x28", v, 0);
    rd(8'h50, v); check("R12 past end", v, 0);
    bus_rd = 1'b0; bus_addr = A_BASE; @(posedge clk); @(negedge clk);
    check("R12 no strobe no data", bus_rdata, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset;
    t_prio_pack;
    t_edge;
    t_clear_zero;
    t_set_wins;
    t_priority;
    t_fast;
    t_disable;
    t_base;
    t_freeze;
    t_unmapped;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule